// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit collects event flags for a bus controller and turns them into one level interrupt and two DMA request lines. A separate transfer engine sets flags by pulsing per-bit set inputs. Host software reaches the unit through a small register port. Through that port it can:

- read the flags;
- clear selected flags by writing ones;
- program a six-bit interrupt enable mask;
- program two DMA enables;
- pull the next pending event through a vector read.

A vector read returns the number of the lowest enabled pending event plus one, and acknowledges that event in the same access. A zero from a vector read means nothing is pending. Each DMA request mirrors one ready flag while its channel is enabled. Turning a channel on removes the matching ready flag from the interrupt mask, so a ready flag is serviced by DMA or by interrupt, never by both. A test write can raise all six low flags at once, which lets software exercise the interrupt path.

All state sits in one register stage. Outputs come from that stage through combinational logic, so any register access becomes visible on the outputs one clock later. Register map (3-bit address): 0 flags, 1 enable mask, 2 vector (read only), 3 DMA enables, 4 test (write only). Reads of any other address return zero.

Top module: `isv_top`

## Requirements
- R1: `irq` is 1 exactly when some bit i in 0..5 has both flag i and enable-mask bit i set.
- R2: A read at address 2 returns k+1, where k is the lowest bit in 0..5 with flag k and mask bit k both set, and clears only flag k. With no such bit, the read returns 0 and changes nothing.
- R3: A write at address 0 clears the flags at the positions that are 1 in both the written value and 0x0027 (bits 0, 1, 2, 5). Every other flag, including bits 3 and 4, keeps its value.
- R4: A write at address 1 stores bits 5:0 of the data as the mask. A read at address 1 returns the mask zero-extended.
- R5: A write at address 3 stores data bit 15 as the receive DMA enable and bit 7 as the transmit DMA enable; a read returns them at those positions and zero elsewhere. Writing 1 to bit 15 clears mask bit 3, and writing 1 to bit 7 clears mask bit 4.
- R6: `rx_dreq` equals flag 3 while receive DMA is enabled and is 0 otherwise. `tx_dreq` equals flag 4 while transmit DMA is enabled and is 0 otherwise.
- R7: A read at address 0 returns the stored flags, with bit 12 replaced by the current `bus_busy` input.
- R8: A write at address 4 with data bit 11 set sets flags 0 through 5. With bit 11 clear, the write changes nothing.
- R9: Each `evt_set` bit sets its flag at the clock edge. A set wins over a software clear or a vector acknowledge of the same flag in the same cycle.
- R10: After reset, flags, mask and DMA enables are all zero, and every output is 0.
- R11: The outputs reflect a register access from the clock edge that ends the access. A vector read that removes the last enabled pending event drops `irq` in the next cycle.
- R12: Reads at addresses 4 to 7 return zero. Writes at addresses 2 and 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access valid this cycle |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of a read |
| evt_set | input | 16 | Per-flag set pulses from the transfer engine |
| bus_busy | input | 1 | Current bus-busy state, shown in flag bit 12 on reads |
| irq | output | 1 | Level interrupt |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |

## Verification
The properties assume that at most one register access happens per cycle. Under that assumption, a software clear, a mask or DMA change, and a vector acknowledge never land on the same edge. The only same-edge contention is therefore between `evt_set` and one host action. The properties allow for that case by excusing any flag that is being set in that cycle.

The stimulus drives `reg_en`, `reg_wr` and `reg_addr` as one access per cycle. It overlaps set pulses with clears and acknowledges of the very same flag on purpose, to exercise the set-wins rule.

// File: rtl/isv_pkg.sv
package isv_pkg;
    localparam int ISV_AW = 3;
    typedef logic [ISV_AW-1:0] isv_addr_t;

    localparam isv_addr_t ISV_A_FLAGS = 3'd0;
    localparam isv_addr_t ISV_A_MASK  = 3'd1;
    localparam isv_addr_t ISV_A_VEC   = 3'd2;
    localparam isv_addr_t ISV_A_DMA   = 3'd3;
    localparam isv_addr_t ISV_A_TEST  = 3'd4;
endpackage

// File: rtl/isv_lsb_pick.sv
// Finds the lowest set bit of a request vector.
module isv_lsb_pick #(
    parameter int W = 6,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  pend,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [W-1:0] below;
    logic [W-1:0] first;

    assign below[0] = 1'b0;
    generate
        for (genvar i = 1; i < W; i++) begin : g_below
            assign below[i] = below[i-1] | pend[i-1];
        end
    endgenerate

    assign first = pend & ~below;
    assign found = |pend;

    always_comb begin
        idx = '0;
        for (int k = 0; k < W; k++) begin
            if (first[k]) idx = idx | IW'(k);
        end
    end
endmodule

// File: rtl/isv_req_gen.sv
// Interrupt and DMA request outputs from registered state.
module isv_req_gen #(
    parameter int EN_W = 6
) (
    input  logic [EN_W-1:0] flags_low,
    input  logic [EN_W-1:0] mask,
    input  logic            rx_flag,
    input  logic            tx_flag,
    input  logic            rx_en,
    input  logic            tx_en,
    output logic            irq,
    output logic            rx_dreq,
    output logic            tx_dreq
);
    assign irq     = |(flags_low & mask);
    assign rx_dreq = rx_en & rx_flag;
    assign tx_dreq = tx_en & tx_flag;
endmodule

// File: rtl/isv_top.sv
module isv_top #(
    parameter int STAT_W     = 16,
    parameter int EN_W       = 6,
    parameter int BUSY_BIT   = 12,
    parameter int RX_BIT     = 3,
    parameter int TX_BIT     = 4,
    parameter int TEST_BIT   = 11,
    parameter int RX_DMA_BIT = 15,
    parameter int TX_DMA_BIT = 7,
    parameter logic [STAT_W-1:0] SW_CLR_MASK = STAT_W'('h0027)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic [STAT_W-1:0] evt_set,
    input  logic              bus_busy,
    output logic              irq,
    output logic              rx_dreq,
    output logic              tx_dreq
);
    import isv_pkg::*;

    localparam int IDX_W = (EN_W > 1) ? $clog2(EN_W) : 1;
    localparam int VEC_W = $clog2(EN_W + 1);
    localparam logic [STAT_W-1:0] FORCE_BITS = STAT_W'({EN_W{1'b1}});

    typedef struct packed {
        logic [STAT_W-1:0] flags;
        logic [EN_W-1:0]   mask;
        logic              rx_en;
        logic              tx_en;
    } isv_state_t;

    isv_state_t st_d, st_q;

    logic              acc_wr, acc_rd;
    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    logic [VEC_W-1:0]  vec_code;
    logic [STAT_W-1:0] clr_bits, force_bits;
    logic [STAT_W-1:0] rd_mux;

    assign acc_wr = reg_en & reg_wr;
    assign acc_rd = reg_en & ~reg_wr;

    isv_lsb_pick #(.W(EN_W)) u_pick (
        .pend  (st_q.flags[EN_W-1:0] & st_q.mask),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign vec_code = pick_found ? (VEC_W'(pick_idx) + VEC_W'(1)) : '0;

    // next-state
    always_comb begin
        st_d       = st_q;
        clr_bits   = '0;
        force_bits = '0;
        if (acc_wr) begin
            case (reg_addr)
                ISV_A_FLAGS: clr_bits = reg_wdata & SW_CLR_MASK;
                ISV_A_MASK:  st_d.mask = reg_wdata[EN_W-1:0];
                ISV_A_DMA: begin
                    st_d.rx_en = reg_wdata[RX_DMA_BIT];
                    st_d.tx_en = reg_wdata[TX_DMA_BIT];
                    if (reg_wdata[RX_DMA_BIT]) st_d.mask[RX_BIT] = 1'b0;
                    if (reg_wdata[TX_DMA_BIT]) st_d.mask[TX_BIT] = 1'b0;
                end
                ISV_A_TEST: if (reg_wdata[TEST_BIT]) force_bits = FORCE_BITS;
                default: ;
            endcase
        end
        if (acc_rd && (reg_addr == ISV_A_VEC) && pick_found) begin
            clr_bits = clr_bits | (STAT_W'(1) << pick_idx);
        end
        st_d.flags = (st_q.flags & ~clr_bits) | force_bits | evt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read data
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            ISV_A_FLAGS: begin
                rd_mux           = st_q.flags;
                rd_mux[BUSY_BIT] = bus_busy;
            end
            ISV_A_MASK:  rd_mux[EN_W-1:0]  = st_q.mask;
            ISV_A_VEC:   rd_mux[VEC_W-1:0] = vec_code;
            ISV_A_DMA: begin
                rd_mux[RX_DMA_BIT] = st_q.rx_en;
                rd_mux[TX_DMA_BIT] = st_q.tx_en;
            end
            default: ;
        endcase
        reg_rdata = acc_rd ? rd_mux : '0;
    end

    isv_req_gen #(.EN_W(EN_W)) u_req (
        .flags_low (st_q.flags[EN_W-1:0]),
        .mask      (st_q.mask),
        .rx_flag   (st_q.flags[RX_BIT]),
        .tx_flag   (st_q.flags[TX_BIT]),
        .rx_en     (st_q.rx_en),
        .tx_en     (st_q.tx_en),
        .irq       (irq),
        .rx_dreq   (rx_dreq),
        .tx_dreq   (tx_dreq)
    );
endmodule

// File: rtl/isv_chk.sv
module isv_chk #(
    parameter int STAT_W     = 16,
    parameter int EN_W       = 6,
    parameter int RX_BIT     = 3,
    parameter int TX_BIT     = 4,
    parameter int TEST_BIT   = 11,
    parameter int RX_DMA_BIT = 15,
    parameter int TX_DMA_BIT = 7,
    parameter logic [STAT_W-1:0] SW_CLR_MASK = STAT_W'('h0027),
    localparam int VEC_W = $clog2(EN_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_en,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [STAT_W-1:0] reg_wdata,
    input logic [STAT_W-1:0] evt_set,
    input logic [STAT_W-1:0] flags_q,
    input logic [EN_W-1:0]   mask_q,
    input logic              rx_en_q,
    input logic              tx_en_q,
    input logic [VEC_W-1:0]  vec_code,
    input logic              irq,
    input logic              rx_dreq,
    input logic              tx_dreq
);
    import isv_pkg::*;

    logic rd_vec, wr_flags, wr_dma, wr_test;
    logic [STAT_W-1:0] vec_bit;

    assign rd_vec   = reg_en && !reg_wr && (reg_addr == ISV_A_VEC);
    assign wr_flags = reg_en && reg_wr && (reg_addr == ISV_A_FLAGS);
    assign wr_dma   = reg_en && reg_wr && (reg_addr == ISV_A_DMA);
    assign wr_test  = reg_en && reg_wr && (reg_addr == ISV_A_TEST);
    assign vec_bit  = (vec_code != '0) ? (STAT_W'(1) << (vec_code - VEC_W'(1))) : '0;

    // R1
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(flags_q[EN_W-1:0] & mask_q));

    // R2
    vec_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && vec_code != '0) |=> (flags_q & $past(vec_bit & ~evt_set)) == '0);

    // R2
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && vec_code == '0) |-> !irq);

    // R3
    sw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flags |=> (flags_q & $past(flags_q & ~SW_CLR_MASK)) == $past(flags_q & ~SW_CLR_MASK));

    // R5
    rx_mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dma && reg_wdata[RX_DMA_BIT]) |=> !mask_q[RX_BIT]);

    // R5
    tx_mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dma && reg_wdata[TX_DMA_BIT]) |=> !mask_q[TX_BIT]);

    // R6
    rx_dreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dreq == (rx_en_q && flags_q[RX_BIT]));

    // R6
    tx_dreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dreq == (tx_en_q && flags_q[TX_BIT]));

    // R8
    test_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_test && reg_wdata[TEST_BIT]) |=> (&flags_q[EN_W-1:0]));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> (flags_q & $past(evt_set)) == $past(evt_set));
endmodule

bind isv_top isv_chk #(
    .STAT_W(STAT_W), .EN_W(EN_W), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT),
    .TEST_BIT(TEST_BIT), .RX_DMA_BIT(RX_DMA_BIT), .TX_DMA_BIT(TX_DMA_BIT),
    .SW_CLR_MASK(SW_CLR_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .evt_set(evt_set),
    .flags_q(st_q.flags), .mask_q(st_q.mask), .rx_en_q(st_q.rx_en),
    .tx_en_q(st_q.tx_en), .vec_code(vec_code), .irq(irq),
    .rx_dreq(rx_dreq), .tx_dreq(tx_dreq)
);

// File: tb/sim_isv_top.sv
`timescale 1ns/1ps
module sim_isv_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] evt_set = '0;
    logic        bus_busy = 1'b0;
    logic        irq, rx_dreq, tx_dreq;

    int vectors = 0;
    int miscompares = 0;

    // behavioural reference state
    logic [15:0] m_flags = '0;
    logic [5:0]  m_mask  = '0;
    logic        m_rx = 1'b0;
    logic        m_tx = 1'b0;

    always #5 clk = ~clk;

    isv_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_set(evt_set), .bus_busy(bus_busy), .irq(irq),
        .rx_dreq(rx_dreq), .tx_dreq(tx_dreq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pending_vec();
        for (int i = 0; i < 6; i++) begin
            if (m_flags[i] && m_mask[i]) return i + 1;
        end
        return 0;
    endfunction

    function automatic logic [15:0] model_read(input logic [2:0] a, input logic busy);
        logic [15:0] r;
        r = 16'h0000;
        case (a)
            3'd0: begin r = m_flags; r[12] = busy; end
            3'd1: r = {10'd0, m_mask};
            3'd2: r = 16'(pending_vec());
            3'd3: begin r[15] = m_rx; r[7] = m_tx; end
            default: r = 16'h0000;
        endcase
        return r;
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R7";
            3'd1: return "R4";
            3'd2: return "R2";
            3'd3: return "R5";
            default: return "R12";
        endcase
    endfunction

    task automatic model_update(input logic en, input logic wr, input logic [2:0] a,
                                input logic [15:0] wd, input logic [15:0] set);
        int v;
        if (en && wr) begin
            case (a)
                3'd0: m_flags = m_flags & ~(wd & 16'h0027);
                3'd1: m_mask = wd[5:0];
                3'd3: begin
                    m_rx = wd[15];
                    m_tx = wd[7];
                    if (wd[15]) m_mask[3] = 1'b0;
                    if (wd[7])  m_mask[4] = 1'b0;
                end
                3'd4: if (wd[11]) m_flags[5:0] = 6'h3f;
                default: ;
            endcase
        end
        if (en && !wr && a == 3'd2) begin
            v = pending_vec();
            if (v != 0) m_flags[v-1] = 1'b0;
        end
        m_flags = m_flags | set;
    endtask

    task automatic step(input logic en, input logic wr, input logic [2:0] a,
                        input logic [15:0] wd, input logic [15:0] set, input logic busy);
        @(negedge clk);
        reg_en = en; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        evt_set = set; bus_busy = busy;
        #4;
        if (en && !wr) chk(read_tag(a), reg_rdata, model_read(a, busy));
        @(posedge clk);
        model_update(en, wr, a, wd, set);
        #1;
        chk("R1 R11 irq", 16'(irq), 16'(|(m_flags[5:0] & m_mask)));
        chk("R6 rx_dreq", 16'(rx_dreq), 16'(m_rx & m_flags[3]));
        chk("R6 tx_dreq", 16'(tx_dreq), 16'(m_tx & m_flags[4]));
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        step(1'b1, 1'b1, a, d, 16'h0, 1'b0);
    endtask

    task automatic rd(input logic [2:0] a);
        step(1'b1, 1'b0, a, 16'h0, 16'h0, 1'b0);
    endtask

    task automatic pulse(input logic [15:0] s);
        step(1'b0, 1'b0, 3'd0, 16'h0, s, 1'b0);
    endtask

    initial begin
        #1_500_000;
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 irq", 16'(irq), 16'h0);
        chk("R10 dreq", 16'({rx_dreq, tx_dreq}), 16'h0);
        rd(3'd0); rd(3'd1); rd(3'd3); rd(3'd2);

        // R4 mask storage, R1 interrupt level
        wr(3'd1, 16'hffff);
        rd(3'd1);
        pulse(16'h0012);
        pulse(16'h0080);
        // R2 vector order and acknowledge, R11 irq drop
        rd(3'd2); rd(3'd2); rd(3'd2);
        rd(3'd0);

        // R3 software clear
        pulse(16'h003f);
        wr(3'd0, 16'hffff);
        rd(3'd0);
        wr(3'd0, 16'h0018);
        rd(3'd0);

        // R5 DMA enables and mask interaction, R6 requests
        wr(3'd1, 16'h003f);
        wr(3'd3, 16'hffff);
        rd(3'd3); rd(3'd1);
        pulse(16'h0008);
        pulse(16'h0010);
        wr(3'd3, 16'h0080);
        rd(3'd3);
        wr(3'd3, 16'h0000);

        // R7 bus busy on flag reads
        pulse(16'h1000);
        step(1'b1, 1'b0, 3'd0, 16'h0, 16'h0, 1'b1);
        step(1'b1, 1'b0, 3'd0, 16'h0, 16'h0, 1'b0);

        // R8 self-test force
        wr(3'd0, 16'h0027);
        wr(3'd4, 16'h0007);
        rd(3'd0);
        wr(3'd4, 16'h0800);
        rd(3'd0);

        // R9 set beats clear and acknowledge
        wr(3'd1, 16'h0001);
        step(1'b1, 1'b1, 3'd0, 16'h0001, 16'h0001, 1'b0);
        rd(3'd0);
        step(1'b1, 1'b0, 3'd2, 16'h0, 16'h0001, 1'b0);
        rd(3'd2);

        // R12 unmapped and read-only addresses
        wr(3'd2, 16'hffff); wr(3'd5, 16'hffff); wr(3'd6, 16'hffff); wr(3'd7, 16'hffff);
        rd(3'd0); rd(3'd1); rd(3'd3);
        rd(3'd4); rd(3'd5); rd(3'd6); rd(3'd7);

        // mixed traffic
        for (int n = 0; n < 2000; n++) begin
            logic [15:0] s;
            s = (($urandom % 4) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
            step(1'($urandom), 1'($urandom), 3'($urandom), 16'($urandom), s, 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule